// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block passes data between two byte-wide ports, A and B, in both directions without inverting it. Each direction owns a bank of storage elements and three active-low controls: a direction enable, a latch enable and an output enable. The direction enable gates the other two. While the direction enable and the latch enable are both low, the bank is open and the far port follows the near port in the same cycle. When the latch enable goes high, the bank keeps the last value it sampled and keeps presenting it.

The storage is built from clocked samplers that run at the fast system clock, so no transparent latch is inferred. An open bank loads the near-port input on every rising clock edge. A closed bank keeps its value. Each port is split into an input bus, an output bus and a per-bit drive-enable vector, so a wrapper at the pad level can build the three-state pins. The two directions are fully independent, and each can hold its own word while the other passes or holds a different one.

Top module: `latched_bus_xcvr`

## Requirements
- R1: During reset both storage banks are cleared to zero. After reset, a closed bank whose output is enabled presents 0x00 on its output bus.
- R2: While a direction's enable is high, that direction's output-enable vector is all zeros, whatever the latch and output enables are.
- R3: While a direction's output enable is high, that direction's output-enable vector is all zeros.
- R4: While a direction's enable and output enable are both low, every bit of that direction's output-enable vector is one.
- R5: While a direction's enable and latch enable are both low, its output bus equals its input bus in the same cycle (bit i out equals bit i in, no inversion).
- R6: On the first cycle the bank is closed after being open, the output shows the input sampled at the last rising clock edge while the bank was open. The output then stays at that value while the bank stays closed, even if the input changes.
- R7: A high direction enable keeps the bank closed even with the latch enable low. Input changes made while the direction enable is high are ignored, and the held word reappears when the output is enabled again.
- R8: The A-to-B and B-to-A banks are independent. Each can hold a different word at the same time, and the controls of one direction have no effect on the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; banks sample on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| aIn | input | W | Data arriving on port A |
| aOut | output | W | Data for port A (from the B-to-A path) |
| aOe | output | W | Per-bit drive enable for port A |
| bIn | input | W | Data arriving on port B |
| bOut | output | W | Data for port B (from the A-to-B path) |
| bOe | output | W | Per-bit drive enable for port B |
| abEnN | input | 1 | A-to-B direction enable, active low |
| abLatchN | input | 1 | A-to-B latch enable, active low |
| abDriveN | input | 1 | A-to-B output enable, active low |
| baEnN | input | 1 | B-to-A direction enable, active low |
| baLatchN | input | 1 | B-to-A latch enable, active low |
| baDriveN | input | 1 | B-to-A output enable, active low |

## Verification
The output enables and the pass-through path are combinational, so their results are due in the same cycle as the stimulus. A capture lands on the rising edge that ends an open cycle, and the held word is due from the next cycle on. The bench changes inputs 1 ns after each rising edge and compares at the following falling edge. A reference copy of each bank in the bench loads on the same rising edges, so every comparison sees settled values with the right number of edges in between.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from a direction's control decode to its data path.
  typedef struct packed {
    logic latchOpen;  // bank loads its input on each rising edge; output bypasses
    logic drive;      // far-port output enable
  } dirStrobe_t;

endpackage

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_pkg::*;
(
  input  logic       enN,
  input  logic       latchN,
  input  logic       driveN,
  output dirStrobe_t strobe
);

  logic enActive;

  assign enActive = ~enN;

  always_comb begin
    strobe.latchOpen = enActive & ~latchN;
    strobe.drive     = enActive & ~driveN;
  end

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dirStrobe_t   strobe,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] dOut,
  output logic [W-1:0] dOe
);

  logic [W-1:0] stored;

  // One sampler per bit, so each bit can be mapped to its own cell.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                stored[i] <= 1'b0;
      else if (strobe.latchOpen) stored[i] <= dIn[i];
    end
    assign dOut[i] = strobe.latchOpen ? dIn[i] : stored[i];
    assign dOe[i]  = strobe.drive;
  end

endmodule

// File: rtl/latched_bus_xcvr.sv
module latched_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] aIn,
  output logic [W-1:0] aOut,
  output logic [W-1:0] aOe,
  input  logic [W-1:0] bIn,
  output logic [W-1:0] bOut,
  output logic [W-1:0] bOe,
  input  logic         abEnN,
  input  logic         abLatchN,
  input  logic         abDriveN,
  input  logic         baEnN,
  input  logic         baLatchN,
  input  logic         baDriveN
);

  dirStrobe_t abStrobe;
  dirStrobe_t baStrobe;

  xcvr_dir_ctrl u_abCtrl (
    .enN    (abEnN),
    .latchN (abLatchN),
    .driveN (abDriveN),
    .strobe (abStrobe)
  );

  xcvr_dir_ctrl u_baCtrl (
    .enN    (baEnN),
    .latchN (baLatchN),
    .driveN (baDriveN),
    .strobe (baStrobe)
  );

  xcvr_latch_bank #(.W(W)) u_abBank (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (abStrobe),
    .dIn    (aIn),
    .dOut   (bOut),
    .dOe    (bOe)
  );

  xcvr_latch_bank #(.W(W)) u_baBank (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (baStrobe),
    .dIn    (bIn),
    .dOut   (aOut),
    .dOe    (aOe)
  );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] aIn,
  input logic [W-1:0] aOut,
  input logic [W-1:0] aOe,
  input logic [W-1:0] bIn,
  input logic [W-1:0] bOut,
  input logic [W-1:0] bOe,
  input logic         abEnN,
  input logic         abLatchN,
  input logic         abDriveN,
  input logic         baEnN,
  input logic         baLatchN,
  input logic         baDriveN
);

  logic abOpen, baOpen;
  assign abOpen = !abEnN && !abLatchN;
  assign baOpen = !baEnN && !baLatchN;

  assert_ab_off_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    abEnN |-> bOe == '0);
  assert_ba_off_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    baEnN |-> aOe == '0);

  assert_ab_off_drv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abDriveN |-> bOe == '0);
  assert_ba_off_drv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    baDriveN |-> aOe == '0);

  assert_ab_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!abEnN && !abDriveN) |-> bOe == '1);
  assert_ba_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!baEnN && !baDriveN) |-> aOe == '1);

  assert_ab_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    abOpen |-> bOut == aIn);
  assert_ba_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    baOpen |-> aOut == bIn);

  assert_ab_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(abOpen) && !abOpen) |-> bOut == $past(aIn));
  assert_ba_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(baOpen) && !baOpen) |-> aOut == $past(bIn));

  assert_ab_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(abOpen) && !abOpen) |-> $stable(bOut));
  assert_ba_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(baOpen) && !baOpen) |-> $stable(aOut));

endmodule

bind latched_bus_xcvr xcvr_checker #(.W(W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .aIn      (aIn),
  .aOut     (aOut),
  .aOe      (aOe),
  .bIn      (bIn),
  .bOut     (bOut),
  .bOe      (bOe),
  .abEnN    (abEnN),
  .abLatchN (abLatchN),
  .abDriveN (abDriveN),
  .baEnN    (baEnN),
  .baLatchN (baLatchN),
  .baDriveN (baDriveN)
);

// File: tb/tb_latched_bus_xcvr.sv
`timescale 1ns/1ps
module tb_latched_bus_xcvr;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOe, bOut, bOe;
  logic abEnN = 1'b1, abLatchN = 1'b1, abDriveN = 1'b1;
  logic baEnN = 1'b1, baLatchN = 1'b1, baDriveN = 1'b1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [W-1:0] refAb, refBa;

  always #2.5 clk = ~clk;

  latched_bus_xcvr #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .abEnN(abEnN), .abLatchN(abLatchN), .abDriveN(abDriveN),
    .baEnN(baEnN), .baLatchN(baLatchN), .baDriveN(baDriveN)
  );

  // Reference banks, loaded from the requirements (R1, R6, R7).
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refAb <= '0;
      refBa <= '0;
    end else begin
      if (!abEnN && !abLatchN) refAb <= aIn;
      if (!baEnN && !baLatchN) refBa <= bIn;
    end
  end

  function automatic logic [W-1:0] expData(logic enN, logic latchN,
                                           logic [W-1:0] held, logic [W-1:0] din);
    return (!enN && !latchN) ? din : held;
  endfunction

  function automatic logic [W-1:0] expOe(logic enN, logic driveN);
    return (!enN && !driveN) ? '1 : '0;
  endfunction

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkAll(string tag);
    logic [W-1:0] eBOe, eAOe;
    eBOe = expOe(abEnN, abDriveN);
    eAOe = expOe(baEnN, baDriveN);
    cmp(tag, "bOe", bOe, eBOe);
    cmp(tag, "aOe", aOe, eAOe);
    if (eBOe[0]) cmp(tag, "bOut", bOut, expData(abEnN, abLatchN, refAb, aIn));
    if (eAOe[0]) cmp(tag, "aOut", aOut, expData(baEnN, baLatchN, refBa, bIn));
  endtask

  task automatic cyc(string tag);
    @(negedge clk);
    checkAll(tag);
    @(posedge clk);
    #1;
  endtask

  task automatic setAb(logic en, logic le, logic oe);
    abEnN = en; abLatchN = le; abDriveN = oe;
  endtask

  task automatic setBa(logic en, logic le, logic oe);
    baEnN = en; baLatchN = le; baDriveN = oe;
  endtask

  initial begin
    #(5 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    // Some enables toggled during reset; banks must still clear (R1).
    setAb(1'b0, 1'b0, 1'b0);
    aIn = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    setAb(1'b0, 1'b1, 1'b0);
    setBa(1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
    #1;
    // R1: closed, driven banks show the cleared word.
    cyc("R1");
    cmp("R1", "bOut-direct", bOut, 8'h00);
    cmp("R1", "aOut-direct", aOut, 8'h00);
    cmp("R4", "bOe-direct", bOe, 8'hFF);

    // R5: open bank passes data in the same cycle.
    setAb(1'b0, 1'b0, 1'b0);
    aIn = 8'h5A;
    cyc("R5");
    aIn = 8'hC3;
    #1;
    cmp("R5", "bOut-direct", bOut, 8'hC3);
    cyc("R5");

    // R6: close the latch; the last sampled word stays although aIn moves.
    setAb(1'b0, 1'b1, 1'b0);
    aIn = 8'h11;
    cyc("R6");
    cmp("R6", "bOut-direct", bOut, 8'hC3);
    aIn = 8'h22;
    cyc("R6");

    // R2: direction enable high blanks the drive, even with latch enable low.
    setAb(1'b1, 1'b0, 1'b0);
    aIn = 8'h77;
    cyc("R2");
    cmp("R2", "bOe-direct", bOe, 8'h00);
    aIn = 8'h78;
    cyc("R2");
    // R7: the word held before reappears.
    setAb(1'b0, 1'b1, 1'b0);
    cyc("R7");
    cmp("R7", "bOut-direct", bOut, 8'hC3);

    // R3: output enable high blanks the drive.
    setAb(1'b0, 1'b1, 1'b1);
    cyc("R3");
    cmp("R3", "bOe-direct", bOe, 8'h00);

    // R8: B-to-A captures 0x3C while A-to-B still holds 0xC3.
    setAb(1'b0, 1'b1, 1'b0);
    setBa(1'b0, 1'b0, 1'b0);
    bIn = 8'h3C;
    cyc("R8");
    setBa(1'b0, 1'b1, 1'b0);
    bIn = 8'hFF;
    aIn = 8'h00;
    cyc("R8");
    cmp("R8", "aOut-direct", aOut, 8'h3C);
    cmp("R8", "bOut-direct", bOut, 8'hC3);

    // Random mix of controls and data, checked against the reference model.
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      setAb(r[0] & r[6], r[1], r[2] & r[7]);
      setBa(r[3] & r[7], r[4], r[5] & r[6]);
      aIn = W'($urandom);
      bIn = W'($urandom);
      cyc("R8");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule